// File: doc/BRIEF.md
# Sign-Aware Leading-Digit Encoder

This block measures how far a 32-bit mantissa must be shifted left so that its first significant digit lands in the top bit position. Before counting, every data bit is compared against a sign input by an exclusive OR. For a positive two's-complement value (sign low), the block therefore counts leading zeros. For a negative value (sign high), it counts leading ones. One encoder serves both representations.

The result is a 5-bit shift count. An all-zero flag accompanies it, because a word with no significant bit and a word whose only significant bit is bit 0 both produce a count of 31. The inversion lives only on the encoder's internal view. Any shifter that consumes the count works on the untouched data word.

Inputs are sampled on the rising clock edge, and both outputs are registered, so a result appears one cycle after its inputs are presented. A synchronous active-high reset parks the outputs in the "nothing significant" state.

Top module: `lead_digit_enc`

## Requirements
- R1: One cycle after inputs are sampled, `shift_cnt` equals the number of bit positions, counted from bit 31 downward, that come before the first bit of `data_in` that differs from `sign_in`.
- R2: When bit 31 of `data_in` differs from `sign_in`, `shift_cnt` is 0 (binary 00000) and `no_digit` is low on the following cycle.
- R3: When bit 0 is the only bit that differs from `sign_in`, `shift_cnt` is 31 (binary 11111) and `no_digit` is low on the following cycle.
- R4: When no bit of `data_in` differs from `sign_in`, `shift_cnt` is 31 and `no_digit` is high on the following cycle. This covers all-zero data with sign low and all-ones data with sign high.
- R5: Whenever `no_digit` is high, `shift_cnt` is 31.
- R6: While `rst` is sampled high, the outputs are forced to `shift_cnt` = 31 and `no_digit` = 1 on the next cycle.
- R7: The sign input only selects which digit value counts as insignificant. With sign high, the count is that of the bitwise-inverted word, so a value and its bitwise complement give the same count under opposite signs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| data_in | input | 32 | Mantissa word to examine |
| sign_in | input | 1 | Sign of the mantissa; a high level inverts the encoder's view of the data |
| shift_cnt | output | 5 | Registered left-shift count that brings the first significant bit to bit 31 |
| no_digit | output | 1 | Registered flag, high when no bit differs from the sign |

## Verification
A fault in the group search or in the group combiner shows up as a wrong `shift_cnt` exactly one cycle after the offending word is applied. Single-bit words at every position, under both sign values, expose each group and each offset inside a group. A fault in the inversion stage appears only under one sign value, so every pattern is applied with both. A wrong zero-detection shows as `no_digit` disagreeing with the count on that same cycle.

// File: rtl/lead_enc_pkg.sv
package lead_enc_pkg;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned GROUP_W = 8;
  localparam int unsigned CNT_W   = $clog2(DATA_W);
endpackage

// File: rtl/sign_flip.sv
module sign_flip #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] raw,
  input  logic         sign,
  output logic [W-1:0] view
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    assign view[b] = raw[b] ^ sign;
  end
endmodule

// File: rtl/group_lzc.sv
module group_lzc #(
  parameter int unsigned G = 8,
  localparam int unsigned GW = (G > 1) ? $clog2(G) : 1
) (
  input  logic [G-1:0]  vec,
  output logic [GW-1:0] cnt,
  output logic          any
);
  always_comb begin
    cnt = '0;
    any = 1'b0;
    for (int i = 0; i < G; i++) begin
      if (vec[i]) begin
        cnt = GW'(G - 1 - i);
        any = 1'b1;
      end
    end
  end
endmodule

// File: rtl/lead_count.sv
module lead_count #(
  parameter int unsigned W = 32,
  parameter int unsigned G = 8,
  localparam int unsigned CW = $clog2(W),
  localparam int unsigned NG = W / G,
  localparam int unsigned GW = (G > 1) ? $clog2(G) : 1
) (
  input  logic [W-1:0]  vec,
  output logic [CW-1:0] cnt,
  output logic          none
);
  logic [GW-1:0] grp_cnt [NG];
  logic [NG-1:0] grp_any;

  for (genvar g = 0; g < NG; g++) begin : g_grp
    group_lzc #(.G(G)) u_grp (
      .vec(vec[g*G +: G]),
      .cnt(grp_cnt[g]),
      .any(grp_any[g])
    );
  end

  always_comb begin
    cnt  = CW'(W - 1);
    none = 1'b1;
    for (int g = 0; g < NG; g++) begin
      if (grp_any[g]) begin
        cnt  = CW'((NG - 1 - g) * G) + CW'(grp_cnt[g]);
        none = 1'b0;
      end
    end
  end
endmodule

// File: rtl/lead_digit_enc.sv
module lead_digit_enc
  import lead_enc_pkg::*;
#(
  parameter int unsigned W = DATA_W,
  parameter int unsigned G = GROUP_W,
  localparam int unsigned CW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [W-1:0]  data_in,
  input  logic          sign_in,
  output logic [CW-1:0] shift_cnt,
  output logic          no_digit
);
  logic [W-1:0]  flipped;
  logic [CW-1:0] cnt_c;
  logic          none_c;

  sign_flip #(.W(W)) u_flip (
    .raw (data_in),
    .sign(sign_in),
    .view(flipped)
  );

  lead_count #(.W(W), .G(G)) u_cnt (
    .vec (flipped),
    .cnt (cnt_c),
    .none(none_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      shift_cnt <= '1;
      no_digit  <= 1'b1;
    end else begin
      shift_cnt <= cnt_c;
      no_digit  <= none_c;
    end
  end
endmodule

// File: rtl/lead_digit_enc_chk.sv
module lead_digit_enc_chk #(
  parameter int unsigned W = 32,
  parameter int unsigned CW = 5
) (
  input logic          clk,
  input logic          rst,
  input logic [W-1:0]  data_in,
  input logic          sign_in,
  input logic [CW-1:0] shift_cnt,
  input logic          no_digit
);
  p_top_bit_r2: assert property (@(posedge clk) disable iff (rst)
    (data_in[W-1] != sign_in) |=> (shift_cnt == '0 && !no_digit));

  p_low_only_r3: assert property (@(posedge clk) disable iff (rst)
    ((data_in ^ {W{sign_in}}) == W'(1)) |=> (shift_cnt == '1 && !no_digit));

  p_empty_r4: assert property (@(posedge clk) disable iff (rst)
    (data_in == {W{sign_in}}) |=> (no_digit && shift_cnt == '1));

  p_flag_cnt_r5: assert property (@(posedge clk) disable iff (rst)
    no_digit |-> shift_cnt == '1);

  p_found_r1: assert property (@(posedge clk) disable iff (rst)
    (data_in != {W{sign_in}}) |=> !no_digit);
endmodule

bind lead_digit_enc lead_digit_enc_chk #(.W(W), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .data_in(data_in), .sign_in(sign_in),
  .shift_cnt(shift_cnt), .no_digit(no_digit)
);

// File: tb/lead_digit_enc_test.sv
module lead_digit_enc_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] data_in = '0;
  logic        sign_in = 1'b0;
  logic [4:0]  shift_cnt;
  logic        no_digit;
  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  lead_digit_enc uut (
    .clk(clk), .rst(rst), .data_in(data_in), .sign_in(sign_in),
    .shift_cnt(shift_cnt), .no_digit(no_digit)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual %0d cycles, expected under 20000", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  function automatic void ref_enc(input logic [31:0] d, input logic s,
                                  output logic [4:0] c, output logic z);
    logic [31:0] x;
    x = d ^ {32{s}};
    c = 5'd31;
    z = 1'b1;
    for (int i = 0; i < 32; i++) begin
      if (z && x[31-i]) begin
        c = 5'(i);
        z = 1'b0;
      end
    end
  endfunction

  task automatic apply_check(input string req, input logic [31:0] d, input logic s);
    logic [4:0] ec;
    logic ez;
    @(negedge clk);
    data_in = d;
    sign_in = s;
    @(negedge clk);
    ref_enc(d, s, ec, ez);
    checks++;
    if (shift_cnt !== ec || no_digit !== ez) begin
      fails++;
      $display("FAIL %s: data=%h sign=%b actual cnt=%0d flag=%b expected cnt=%0d flag=%b",
               req, d, s, shift_cnt, no_digit, ec, ez);
    end
  endtask

  task automatic t_reset;
    rst = 1'b1;
    data_in = 32'h8000_0000;
    repeat (2) @(negedge clk);
    checks++;
    if (shift_cnt !== 5'd31 || no_digit !== 1'b1) begin
      fails++;
      $display("FAIL R6: actual cnt=%0d flag=%b expected cnt=31 flag=1", shift_cnt, no_digit);
    end
    rst = 1'b0;
  endtask

  task automatic t_single_bits;
    for (int s = 0; s < 2; s++) begin
      for (int p = 0; p < 32; p++) begin
        logic [31:0] w;
        w = (32'h1 << p) ^ {32{s[0]}};
        if (p == 31) apply_check("R2", w, s[0]);
        else if (p == 0) apply_check("R3", w, s[0]);
        else apply_check("R1", w, s[0]);
      end
    end
  endtask

  task automatic t_extremes;
    apply_check("R4", 32'h0000_0000, 1'b0);
    apply_check("R4", 32'hFFFF_FFFF, 1'b1);
    apply_check("R2", 32'hFFFF_FFFF, 1'b0);
    apply_check("R2", 32'h0000_0000, 1'b1);
    apply_check("R5", 32'h0000_0000, 1'b0);
  endtask

  task automatic t_complement;
    for (int k = 0; k < 40; k++) begin
      logic [31:0] w;
      w = $urandom() >> (k % 32);
      apply_check("R7", w, 1'b0);
      apply_check("R7", ~w, 1'b1);
    end
  endtask

  task automatic t_random;
    for (int k = 0; k < 200; k++) begin
      logic [31:0] w;
      w = $urandom();
      if (k % 4 == 1) w = w >> ($urandom() % 32);
      apply_check("R1", w, k[0]);
    end
  endtask

  initial begin
    t_reset();
    t_single_bits();
    t_extremes();
    t_complement();
    t_random();
    t_reset();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule